// File: doc/BRIEF.md
# Stepper Bridge Enable and Fault Supervisor

This block is the supervisory control for a two-winding bipolar stepper driver. It takes the driver's active-low sleep, enable and indexer-reset controls and three synchronous detector bits for overcurrent, overtemperature and supply undervoltage. From these it produces the bridge-enable command, a high-impedance command for the output stage, a clear for the microstep indexer, a step-accept gate with a one-cycle qualified step pulse, and an active-low fault flag.

An overcurrent indication must persist for a qualification window of `OC_QUAL` cycles before it trips. Once tripped, it stays latched until the indexer-reset control is applied or the supply drops below its threshold. Overtemperature blocks the bridges only while it is present. Sleep forces the bridges off and masks the other controls. After sleep ends, and after every power-up or undervoltage event, a wake-up window of `WAKE_CYC` cycles must pass before step edges are accepted. The defaults give about 1 ms at 200 MHz.

Top module: `stepguard`

## Requirements
- R1: Once the block reset `rst_n` is released with the supply good, the overcurrent latch is clear (`fault_n` = 1), the bridges may drive, and `step_ok` stays 0 until the wake-up window has run.
- R2: While `sleep_n` = 0, `bridge_en` = 0 and `out_hiz` = 1, no step pulse is produced, `index_rst_n` has no effect (`indexer_clr` = 0, the latch is kept), and `ot_det` does not pull `fault_n` low.
- R3: `step_ok` rises only after `sleep_n` has been 1 with `uv_det` = 0 on exactly `WAKE_CYC` consecutive clock edges. It stays 0 after `WAKE_CYC`-1 such edges.
- R4: With `enable_n` = 1, `bridge_en` = 0, `out_hiz` = 1 and step edges are ignored. With `enable_n` = 0, and nothing else blocking, `bridge_en` = 1 and `out_hiz` = 0.
- R5: With `sleep_n` = 1 and `index_rst_n` = 0, `indexer_clr` = 1, `bridge_en` = 0 and `step_ok` = 0, and the overcurrent latch is cleared on the next edge.
- R6: The overcurrent latch sets on the edge where `oc_det` has been 1 for `OC_QUAL` consecutive edges while awake, powered and not held in reset. Any shorter run leaves the latch clear and restarts the count.
- R7: Once set, the overcurrent latch keeps `fault_n` = 0 and `bridge_en` = 0 after `oc_det` falls, and through changes on `enable_n`, until R5 or R9 clears it.
- R8: `ot_det` = 1 forces `bridge_en` = 0 and `fault_n` = 0 in the same cycle. Both recover in the cycle `ot_det` returns to 0.
- R9: `uv_det` = 1 forces `bridge_en` = 0, `out_hiz` = 1, `indexer_clr` = 1 and `step_ok` = 0. It clears the overcurrent latch, masks `ot_det` from `fault_n`, and restarts the wake-up window.
- R10: `step_pulse` is high for exactly one cycle, in the cycle after the edge that samples a 0-to-1 change of `step_in` while `step_ok` = 1. A level held high gives no further pulse.
- R11: `fault_n` = 0 exactly when the overcurrent latch is set, or when `ot_det` = 1 while awake and powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_n | input | 1 | Low puts the driver to sleep |
| enable_n | input | 1 | Low lets the bridges drive and steps through |
| index_rst_n | input | 1 | Low clears the indexer and the overcurrent latch |
| oc_det | input | 1 | Raw overcurrent detector bit |
| ot_det | input | 1 | Overtemperature detector bit |
| uv_det | input | 1 | Supply undervoltage detector bit |
| step_in | input | 1 | Step request, acted on at its rising edge |
| bridge_en | output | 1 | Bridges may drive the windings |
| out_hiz | output | 1 | Output stage to high impedance |
| indexer_clr | output | 1 | Return the indexer to its home state |
| step_ok | output | 1 | Step edges are currently accepted |
| step_pulse | output | 1 | One-cycle qualified step |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The bench builds the block with `OC_QUAL` = 5 and `WAKE_CYC` = 20. With these values the overcurrent trip edge and the wake-up boundary can each be checked one cycle before and on the cycle they take effect, and a burst one cycle short of the window can be shown not to trip. The small wake-up window also lets the bench cover wake-up after power-up, after sleep and after undervoltage in one short run.

// File: rtl/stepguard_pkg.sv
`timescale 1ns/1ps
package stepguard_pkg;

  // Counter width able to hold the value "limit".
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Qualified control conditions shared by the top level.
  typedef struct packed {
    logic awake;    // not in sleep
    logic powered;  // supply above threshold
    logic held;     // indexer reset requested while awake
    logic run;      // awake, powered, not held, enabled
  } gate_t;

endpackage

// File: rtl/stepguard_ocp.sv
`timescale 1ns/1ps
module stepguard_ocp #(
  parameter int unsigned OC_QUAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic watch,
  input  logic oc_det,
  output logic latched
);
  import stepguard_pkg::*;

  localparam int unsigned CW = cnt_bits(OC_QUAL);
  localparam logic [CW-1:0] LAST = CW'(OC_QUAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lat_q, lat_d;
  logic          upd;

  always_comb begin
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (clr) begin
      cnt_d = '0;
      lat_d = 1'b0;
    end else if (watch) begin
      if (!oc_det) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        lat_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd = clr | watch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;
endmodule

// File: rtl/stepguard_wake.sv
`timescale 1ns/1ps
module stepguard_wake #(
  parameter int unsigned WAKE_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  import stepguard_pkg::*;

  localparam int unsigned CW = cnt_bits(WAKE_CYC);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run;

  assign run = restart | (cnt_q != FULL);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == FULL);
endmodule

// File: rtl/stepguard_edge.sv
`timescale 1ns/1ps
module stepguard_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic allow,
  output logic pulse
);
  logic prev_q;
  logic pulse_q, pulse_d;

  always_comb pulse_d = step_in & ~prev_q & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= step_in;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/stepguard.sv
`timescale 1ns/1ps
module stepguard #(
  parameter int unsigned OC_QUAL  = 64,
  parameter int unsigned WAKE_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic enable_n,
  input  logic index_rst_n,
  input  logic oc_det,
  input  logic ot_det,
  input  logic uv_det,
  input  logic step_in,
  output logic bridge_en,
  output logic out_hiz,
  output logic indexer_clr,
  output logic step_ok,
  output logic step_pulse,
  output logic fault_n
);
  import stepguard_pkg::*;

  gate_t g;
  logic  oc_lat;
  logic  wake_done;
  logic  oc_clr;
  logic  oc_watch;
  logic  wake_restart;

  always_comb begin
    g.awake   = sleep_n;
    g.powered = ~uv_det;
    g.held    = sleep_n & ~index_rst_n;
    g.run     = sleep_n & ~uv_det & index_rst_n & ~enable_n;
  end

  assign oc_clr       = ~g.powered | g.held;
  assign oc_watch     = g.awake & g.powered & ~g.held;
  assign wake_restart = ~g.awake | ~g.powered;

  stepguard_ocp #(.OC_QUAL(OC_QUAL)) u_ocp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (oc_clr),
    .watch   (oc_watch),
    .oc_det  (oc_det),
    .latched (oc_lat)
  );

  stepguard_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wake_restart),
    .done    (wake_done)
  );

  stepguard_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_in (step_in),
    .allow   (step_ok),
    .pulse   (step_pulse)
  );

  assign bridge_en   = g.run & ~oc_lat & ~ot_det;
  assign out_hiz     = ~bridge_en;
  assign indexer_clr = ~g.powered | g.held;
  assign step_ok     = g.run & wake_done;
  assign fault_n     = ~(oc_lat | (ot_det & g.awake & g.powered));
endmodule

// File: rtl/stepguard_chk.sv
`timescale 1ns/1ps
module stepguard_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_n,
  input logic enable_n,
  input logic index_rst_n,
  input logic ot_det,
  input logic uv_det,
  input logic bridge_en,
  input logic indexer_clr,
  input logic step_ok,
  input logic step_pulse,
  input logic fault_n
);
  // R2
  sleep_bridge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !bridge_en);
  // R2
  sleep_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !step_pulse);
  // R3
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_n) |-> !step_ok);
  // R4
  drive_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en |-> (!enable_n && index_rst_n && sleep_n && fault_n));
  // R7
  oc_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !ot_det && !uv_det && (index_rst_n || !sleep_n)) |=> !fault_n);
  // R9
  uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_det |-> (!bridge_en && indexer_clr && !step_ok));
  // R10
  pulse_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $past(step_ok));
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);
endmodule

bind stepguard stepguard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_n     (sleep_n),
  .enable_n    (enable_n),
  .index_rst_n (index_rst_n),
  .ot_det      (ot_det),
  .uv_det      (uv_det),
  .bridge_en   (bridge_en),
  .indexer_clr (indexer_clr),
  .step_ok     (step_ok),
  .step_pulse  (step_pulse),
  .fault_n     (fault_n)
);

// File: tb/stepguard_test.sv
`timescale 1ns/1ps
module stepguard_test;
  localparam int unsigned QUAL = 5;
  localparam int unsigned WAKE = 20;

  logic clk, rst_n, sleep_n, enable_n, index_rst_n;
  logic oc_det, ot_det, uv_det, step_in;
  logic bridge_en, out_hiz, indexer_clr, step_ok, step_pulse, fault_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  stepguard #(.OC_QUAL(QUAL), .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .enable_n(enable_n),
    .index_rst_n(index_rst_n), .oc_det(oc_det), .ot_det(ot_det),
    .uv_det(uv_det), .step_in(step_in), .bridge_en(bridge_en),
    .out_hiz(out_hiz), .indexer_clr(indexer_clr), .step_ok(step_ok),
    .step_pulse(step_pulse), .fault_n(fault_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // advance n falling edges, then settle
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sleep_n = 1'b1; enable_n = 1'b0; index_rst_n = 1'b1;
    oc_det = 1'b0; ot_det = 1'b0; uv_det = 1'b0; step_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    #1;
    chk("R1 fault_n after reset", fault_n, 1'b1);
    chk("R1 bridge_en after reset", bridge_en, 1'b1);
    chk("R1 step_ok after reset", step_ok, 1'b0);
    chk("R4 out_hiz when driving", out_hiz, 1'b0);
    tick(WAKE - 1);
    chk("R3 step_ok one short of wake", step_ok, 1'b0);
    tick(1);
    chk("R3 step_ok at wake", step_ok, 1'b1);
  endtask

  task automatic t_step;
    step_in = 1'b1;
    tick(1);
    chk("R10 pulse after edge", step_pulse, 1'b1);
    tick(1);
    chk("R10 pulse one cycle", step_pulse, 1'b0);
    tick(3);
    chk("R10 held level no pulse", step_pulse, 1'b0);
    step_in = 1'b0;
    enable_n = 1'b1;
    #1;
    chk("R4 hiz when disabled", out_hiz, 1'b1);
    chk("R4 bridge off when disabled", bridge_en, 1'b0);
    tick(1);
    step_in = 1'b1;
    tick(1);
    chk("R4 edge ignored when disabled", step_pulse, 1'b0);
    step_in = 1'b0;
    enable_n = 1'b0;
    tick(1);
  endtask

  task automatic t_sleep;
    sleep_n = 1'b0;
    #1;
    chk("R2 bridge off in sleep", bridge_en, 1'b0);
    chk("R2 hiz in sleep", out_hiz, 1'b1);
    index_rst_n = 1'b0;
    ot_det = 1'b1;
    #1;
    chk("R2 reset ignored in sleep", indexer_clr, 1'b0);
    chk("R2 ot masked in sleep", fault_n, 1'b1);
    step_in = 1'b1;
    tick(1);
    chk("R2 no pulse in sleep", step_pulse, 1'b0);
    step_in = 1'b0;
    index_rst_n = 1'b1;
    ot_det = 1'b0;
    tick(2);
    sleep_n = 1'b1;
    #1;
    chk("R3 gate closed at wake start", step_ok, 1'b0);
    tick(WAKE - 1);
    chk("R3 gate closed one short after sleep", step_ok, 1'b0);
    tick(1);
    chk("R3 gate open after sleep", step_ok, 1'b1);
  endtask

  task automatic t_oc;
    oc_det = 1'b1;
    tick(QUAL - 1);
    chk("R6 short burst no trip", fault_n, 1'b1);
    oc_det = 1'b0;
    tick(1);
    oc_det = 1'b1;
    tick(QUAL - 1);
    chk("R6 count restarted", fault_n, 1'b1);
    tick(1);
    chk("R6 trip at window", fault_n, 1'b0);
    chk("R11 bridge off on trip", bridge_en, 1'b0);
    oc_det = 1'b0;
    enable_n = 1'b1;
    tick(2);
    enable_n = 1'b0;
    tick(3);
    chk("R7 latch holds", fault_n, 1'b0);
    chk("R7 bridge stays off", bridge_en, 1'b0);
    index_rst_n = 1'b0;
    #1;
    chk("R5 indexer clear", indexer_clr, 1'b1);
    chk("R5 step gate closed", step_ok, 1'b0);
    tick(1);
    chk("R5 latch cleared", fault_n, 1'b1);
    index_rst_n = 1'b1;
    #1;
    chk("R5 bridge back", bridge_en, 1'b1);
  endtask

  task automatic t_ot;
    ot_det = 1'b1;
    #1;
    chk("R8 ot fault", fault_n, 1'b0);
    chk("R8 ot bridge off", bridge_en, 1'b0);
    tick(4);
    ot_det = 1'b0;
    #1;
    chk("R8 ot recovered fault", fault_n, 1'b1);
    chk("R8 ot recovered bridge", bridge_en, 1'b1);
  endtask

  task automatic t_uv;
    oc_det = 1'b1;
    tick(QUAL);
    oc_det = 1'b0;
    chk("R11 fault from latch", fault_n, 1'b0);
    uv_det = 1'b1;
    ot_det = 1'b1;
    #1;
    chk("R9 bridge off", bridge_en, 1'b0);
    chk("R9 hiz", out_hiz, 1'b1);
    chk("R9 indexer clear", indexer_clr, 1'b1);
    tick(1);
    chk("R9 latch cleared, ot masked", fault_n, 1'b1);
    ot_det = 1'b0;
    tick(2);
    uv_det = 1'b0;
    #1;
    chk("R9 wake restarted", step_ok, 1'b0);
    tick(WAKE - 1);
    chk("R9 gate closed one short", step_ok, 1'b0);
    tick(1);
    chk("R9 gate open", step_ok, 1'b1);
    chk("R9 fault clear after supply back", fault_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_step();
    t_sleep();
    t_oc();
    t_ot();
    t_uv();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule